// File: doc/BRIEF.md
# SHA-1 Hash Coprocessor with Memory Fetch

This block computes the SHA-1 digest of a byte message that sits in an external SRAM. The SRAM is 32 bits wide and single-ported. Software or a controlling engine supplies three things: a word-aligned byte start address, a length in bytes, and a one-cycle start strobe. From there the block works on its own. It reads the message one word at a time over a clocked memory port and treats each word's bytes as little-endian, so byte lane 0 comes first in the message. It also builds the SHA-1 padding itself: a marker byte, zero fill, and a 64-bit bit count.

Each 512-bit chunk is first collected into a 16-word circular schedule buffer. It is then run through 80 rounds, one round per clock. The chunk's result is added into the chaining words.

When the last chunk has been folded in, the block presents the 160-bit digest and raises a done flag. Both stay put until the next start. A start that arrives while a job is still running is ignored.

Top module: `sha1_fetch_core`

## Requirements
- R1: While `rst_ni` is low, and after reset, `done_o` is 0 and `digest_o` equals the initial chaining value 67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0 (hex). A reset in the middle of a job returns the block to this state at once.
- R2: After an accepted start, the block reads the message from memory and `digest_o` becomes the SHA-1 digest of the message, laid out as {h0,h1,h2,h3,h4} with h0 in bits [159:128].
  - Message byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of the word at byte address `msg_addr_i` + 4*floor(k/4).
  - For example, the word 32'h00636261 with length 3 hashes to a9993e364706816aba3e25717850c26c9cd0d89d.
- R3: A zero-length message produces da39a3ee5e6b4b0d3255bfef95601890afd80709.
- R4: Padding is correct at every chunk boundary. Lengths of 55 bytes or less per final chunk use one padded chunk. Lengths of 56 to 63 bytes spill the length field into an extra chunk. Lengths of 1, 4, 55, 56, 57, 63, 64, 65, 119 and 200 bytes all give correct digests.
- R5: The memory port never writes. `mem_we_o` is always 0, `mem_clk_o` follows `clk_i`, and `mem_addr_o` is always a multiple of 4 when `msg_addr_i` is word aligned.
- R6: A start strobe that arrives while a job is running has no effect. The running job finishes with its own digest.
- R7: `done_o`, once high, stays high and `digest_o` stays stable until the next start. A start accepted while done is high clears `done_o` in the following cycle.
- R8: Every accepted start begins again from the initial chaining value. Back-to-back jobs, and a job after a mid-job reset, each give the digest of their own message only.
- R9: Memory read data is taken one clock after the address is presented. The memory registers the addressed word on the port clock edge, and the block consumes it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; accepted only when no job is running |
| msg_addr_i | input | ADDR_W (16) | Byte address of the first message word; must be word aligned |
| msg_len_i | input | LEN_W (32) | Message length in bytes |
| digest_o | output | 160 | Digest {h0,h1,h2,h3,h4} |
| done_o | output | 1 | High from the end of a job until the next accepted start |
| mem_clk_o | output | 1 | Memory port clock (copy of clk_i) |
| mem_addr_o | output | ADDR_W (16) | Memory byte address, word aligned |
| mem_we_o | output | 1 | Memory write enable, held low |
| mem_wdata_o | output | 32 | Memory write data, held at zero |
| mem_rdata_i | input | 32 | Registered memory read data |

## Verification
Two control decisions can land in the same cycle: a new start strobe, and the holding of a finished result. The bench provokes this by asserting start in the very cycle after `done_o` is first seen high. It then checks that `done_o` drops one cycle later and that the new job's digest belongs only to the new message. A second case pulses start in the middle of a running job. That case is judged by the first job's digest arriving unchanged, and by `done_o` rising only once.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned ROUNDS      = 80;
  localparam int unsigned RND_W       = $clog2(ROUNDS);
  localparam int unsigned SCHED_DEPTH = 16;
  localparam int unsigned SCHED_IDX_W = $clog2(SCHED_DEPTH);
  localparam int unsigned PHASE_LEN   = 20;

  localparam logic [159:0] SHA1_IV = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                      32'h10325476, 32'hC3D2E1F0};

  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] c;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] e;
  } sha1_vars_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_TAKE,
    ST_ROUND,
    ST_DONE
  } core_state_e;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/sha1_word_fmt.sv
module sha1_word_fmt
  import sha1_pkg::*;
#(
  parameter int unsigned LEN_W = 32,
  parameter int unsigned POS_W = LEN_W + 1
) (
  input  logic [POS_W-1:0]       pos_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [WORD_W-1:0]      rdata_i,
  input  logic                   last_chunk_i,
  input  logic [SCHED_IDX_W-1:0] widx_i,
  output logic [WORD_W-1:0]      word_o,
  output logic                   need_fetch_o
);
  localparam int unsigned BYTES = WORD_W / 8;
  localparam logic [SCHED_IDX_W-1:0] LEN_HI_IDX = SCHED_IDX_W'(SCHED_DEPTH - 2);
  localparam logic [SCHED_IDX_W-1:0] LEN_LO_IDX = SCHED_IDX_W'(SCHED_DEPTH - 1);

  logic [POS_W-1:0]  len_ext;
  logic [63:0]       bit_len;
  logic [WORD_W-1:0] data_word;

  assign len_ext = POS_W'(len_i);
  assign bit_len = 64'(len_i) << 3;

  // lane 0 of the memory word becomes the most significant message byte
  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    logic [POS_W-1:0] p;
    assign p = pos_i + POS_W'(j);
    assign data_word[WORD_W-1-8*j -: 8] = (p < len_ext)  ? rdata_i[8*j +: 8] :
                                          (p == len_ext) ? 8'h80 : 8'h00;
  end

  assign need_fetch_o = pos_i < len_ext;

  always_comb begin
    word_o = data_word;
    if (last_chunk_i && widx_i == LEN_HI_IDX) word_o = bit_len[63:32];
    if (last_chunk_i && widx_i == LEN_LO_IDX) word_o = bit_len[31:0];
  end
endmodule

// File: rtl/sha1_sched.sv
module sha1_sched
  import sha1_pkg::*;
#(
  parameter int unsigned DEPTH = SCHED_DEPTH
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [$clog2(DEPTH)-1:0] load_idx_i,
  input  logic [WORD_W-1:0]        load_data_i,
  input  logic                     step_i,
  input  logic [RND_W-1:0]         rnd_i,
  output logic [WORD_W-1:0]        w_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] OFS3  = IDX_W'(DEPTH - 3);
  localparam logic [IDX_W-1:0] OFS8  = IDX_W'(DEPTH - 8);
  localparam logic [IDX_W-1:0] OFS14 = IDX_W'(DEPTH - 14);

  logic [WORD_W-1:0] buf_q [DEPTH];
  logic [IDX_W-1:0]  cur, i3, i8, i14;
  logic [WORD_W-1:0] expanded;
  logic              use_stored;

  assign cur        = rnd_i[IDX_W-1:0];
  assign i3         = cur + OFS3;
  assign i8         = cur + OFS8;
  assign i14        = cur + OFS14;
  assign use_stored = rnd_i < RND_W'(DEPTH);
  assign expanded   = rotl(buf_q[i3] ^ buf_q[i8] ^ buf_q[i14] ^ buf_q[cur], 1);
  assign w_o        = use_stored ? buf_q[cur] : expanded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else if (load_i) begin
      buf_q[load_idx_i] <= load_data_i;
    end else if (step_i && !use_stored) begin
      buf_q[cur] <= expanded;
    end
  end
endmodule

// File: rtl/sha1_round.sv
module sha1_round
  import sha1_pkg::*;
(
  input  sha1_vars_t        v_i,
  input  logic [WORD_W-1:0] w_i,
  input  logic [RND_W-1:0]  rnd_i,
  output sha1_vars_t        v_o
);
  logic [WORD_W-1:0] f, k, temp;

  always_comb begin
    if (rnd_i < RND_W'(PHASE_LEN)) begin
      f = (v_i.b & v_i.c) | (~v_i.b & v_i.d);
      k = 32'h5A827999;
    end else if (rnd_i < RND_W'(2 * PHASE_LEN)) begin
      f = v_i.b ^ v_i.c ^ v_i.d;
      k = 32'h6ED9EBA1;
    end else if (rnd_i < RND_W'(3 * PHASE_LEN)) begin
      f = (v_i.b & v_i.c) | (v_i.b & v_i.d) | (v_i.c & v_i.d);
      k = 32'h8F1BBCDC;
    end else begin
      f = v_i.b ^ v_i.c ^ v_i.d;
      k = 32'hCA62C1D6;
    end
    temp   = rotl(v_i.a, 5) + f + v_i.e + k + w_i;
    v_o.a  = temp;
    v_o.b  = v_i.a;
    v_o.c  = rotl(v_i.b, 30);
    v_o.d  = v_i.c;
    v_o.e  = v_i.d;
  end
endmodule

// File: rtl/sha1_fetch_core.sv
module sha1_fetch_core
  import sha1_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] msg_addr_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  output logic [159:0]      digest_o,
  output logic              done_o,
  output logic              mem_clk_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int unsigned CHUNK_W = LEN_W - 5;
  localparam int unsigned POS_W   = CHUNK_W + SCHED_IDX_W + 2;

  core_state_e              state_q;
  logic [ADDR_W-1:0]        base_q;
  logic [LEN_W-1:0]         len_q;
  logic [CHUNK_W-1:0]       chunk_q;
  logic [SCHED_IDX_W-1:0]   widx_q;
  logic [RND_W-1:0]         rnd_q;
  sha1_vars_t               vars_q;
  logic [159:0]             h_q;

  logic [POS_W-1:0]         pos;
  logic [CHUNK_W-1:0]       last_idx;
  logic                     last_chunk, last_word, last_rnd;
  logic                     busy, need_fetch, load_en;
  logic [WORD_W-1:0]        fmt_word, w_cur;
  sha1_vars_t               vars_nx, h_vars, h_sum;

  assign pos        = {chunk_q, widx_q, 2'b00};
  assign last_idx   = CHUNK_W'(({1'b0, len_q} + (LEN_W+1)'(8)) >> 6);
  assign last_chunk = chunk_q == last_idx;
  assign last_word  = widx_q == '1;
  assign last_rnd   = rnd_q == RND_W'(ROUNDS - 1);
  assign busy       = (state_q == ST_FETCH) || (state_q == ST_TAKE) || (state_q == ST_ROUND);
  assign load_en    = (state_q == ST_FETCH && !need_fetch) || (state_q == ST_TAKE);
  assign h_vars     = h_q;

  assign h_sum.a = h_vars.a + vars_nx.a;
  assign h_sum.b = h_vars.b + vars_nx.b;
  assign h_sum.c = h_vars.c + vars_nx.c;
  assign h_sum.d = h_vars.d + vars_nx.d;
  assign h_sum.e = h_vars.e + vars_nx.e;

  sha1_word_fmt #(
    .LEN_W (LEN_W),
    .POS_W (POS_W)
  ) u_fmt (
    .pos_i        (pos),
    .len_i        (len_q),
    .rdata_i      (mem_rdata_i),
    .last_chunk_i (last_chunk),
    .widx_i       (widx_q),
    .word_o       (fmt_word),
    .need_fetch_o (need_fetch)
  );

  sha1_sched #(
    .DEPTH (SCHED_DEPTH)
  ) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_en),
    .load_idx_i  (widx_q),
    .load_data_i (fmt_word),
    .step_i      (state_q == ST_ROUND),
    .rnd_i       (rnd_q),
    .w_o         (w_cur)
  );

  sha1_round u_round (
    .v_i   (vars_q),
    .w_i   (w_cur),
    .rnd_i (rnd_q),
    .v_o   (vars_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      chunk_q <= '0;
      widx_q  <= '0;
      rnd_q   <= '0;
      vars_q  <= '0;
      h_q     <= SHA1_IV;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i && !busy) begin
            base_q  <= msg_addr_i;
            len_q   <= msg_len_i;
            chunk_q <= '0;
            widx_q  <= '0;
            rnd_q   <= '0;
            h_q     <= SHA1_IV;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH, ST_TAKE: begin
          // address is presented in FETCH; registered data is consumed in TAKE
          if (state_q == ST_FETCH && need_fetch) begin
            state_q <= ST_TAKE;
          end else begin
            widx_q <= widx_q + SCHED_IDX_W'(1);
            if (last_word) begin
              vars_q  <= h_vars;
              state_q <= ST_ROUND;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        ST_ROUND: begin
          vars_q <= vars_nx;
          rnd_q  <= rnd_q + RND_W'(1);
          if (last_rnd) begin
            rnd_q <= '0;
            h_q   <= h_sum;
            if (last_chunk) begin
              state_q <= ST_DONE;
            end else begin
              chunk_q <= chunk_q + CHUNK_W'(1);
              widx_q  <= '0;
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign digest_o    = h_q;
  assign done_o      = state_q == ST_DONE;
  assign mem_clk_o   = clk_i;
  assign mem_addr_o  = base_q + pos[ADDR_W-1:0];
  assign mem_we_o    = 1'b0;
  assign mem_wdata_o = '0;
endmodule

// File: rtl/sha1_fetch_core_chk.sv
module sha1_fetch_core_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         done_o,
  input logic         busy_i,
  input logic [159:0] digest_o,
  input logic [1:0]   addr_lo_i
);
  a_r7_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r7_digest_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(digest_o));

  a_r7_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !done_o);

  a_r6_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (busy_i || done_o));

  a_r6_no_done_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !done_o);

  a_r5_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_lo_i == 2'b00);
endmodule

bind sha1_fetch_core sha1_fetch_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .busy_i    (busy),
  .digest_o  (digest_o),
  .addr_lo_i (mem_addr_o[1:0])
);

// File: tb/test_sha1_fetch_core.sv
`timescale 1ns/1ps
module test_sha1_fetch_core;
  localparam logic [159:0] IV_EXP    = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [159:0] EMPTY_EXP = 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709;
  localparam logic [159:0] ABC_EXP   = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
  localparam int NV = 10;
  localparam logic [15:0] V_ADDR [NV] = '{16'd0, 16'd64, 16'd128, 16'd256, 16'd400,
                                          16'd1024, 16'd1200, 16'd1500, 16'd2000, 16'd2400};
  localparam logic [31:0] V_LEN  [NV] = '{32'd1, 32'd4, 32'd55, 32'd56, 32'd57,
                                          32'd63, 32'd64, 32'd65, 32'd119, 32'd200};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  addr = '0;
  logic [31:0]  len = '0;
  logic [159:0] digest;
  logic         done, mem_clk, mem_we;
  logic [15:0]  mem_addr;
  logic [31:0]  mem_wdata;
  logic [31:0]  mem_rdata = '0;
  logic [31:0]  mem [1024];
  int total = 0;
  int bad = 0;
  int viol = 0;

  always #2 clk = ~clk;

  sha1_fetch_core i_sha1_fetch_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .msg_addr_i  (addr),
    .msg_len_i   (len),
    .digest_o    (digest),
    .done_o      (done),
    .mem_clk_o   (mem_clk),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata)
  );

  // registered single-port memory, read only (R9 latency)
  always @(posedge mem_clk) mem_rdata <= mem[mem_addr[11:2]];

  always @(negedge clk)
    if (rst_n && (mem_we || mem_addr[1:0] != 2'b00 || mem_clk !== clk)) viol++;

  function automatic logic [159:0] ref_sha1(input int base, input int n);
    logic [31:0] h0, h1, h2, h3, h4, a, b, c, d, e, f, k, t, n_u;
    logic [31:0] w [80];
    int nch;
    n_u = n;
    h0 = IV_EXP[159:128]; h1 = IV_EXP[127:96]; h2 = IV_EXP[95:64];
    h3 = IV_EXP[63:32];   h4 = IV_EXP[31:0];
    nch = (n + 8) / 64 + 1;
    for (int ch = 0; ch < nch; ch++) begin
      for (int i = 0; i < 16; i++) begin
        w[i] = '0;
        for (int j = 0; j < 4; j++) begin
          int p;
          int q;
          logic [7:0] by;
          p = ch * 64 + i * 4 + j;
          q = base + p;
          if (p < n) by = mem[q / 4][8 * (q % 4) +: 8];
          else if (p == n) by = 8'h80;
          else by = 8'h00;
          w[i] = {w[i][23:0], by};
        end
      end
      if (ch == nch - 1) begin
        w[14] = {29'd0, n_u[31:29]};
        w[15] = {n_u[28:0], 3'b000};
      end
      for (int i = 16; i < 80; i++) begin
        t = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
        w[i] = {t[30:0], t[31]};
      end
      a = h0; b = h1; c = h2; d = h3; e = h4;
      for (int i = 0; i < 80; i++) begin
        if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
        else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
        else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
        else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
        t = {a[26:0], a[31:27]} + f + e + k + w[i];
        e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
      end
      h0 += a; h1 += b; h2 += c; h3 += d; h4 += e;
    end
    return {h0, h1, h2, h3, h4};
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [15:0] a, input logic [31:0] n);
    @(negedge clk);
    addr = a; len = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    if (!seen) check(1'b0, {req, " timeout"}, 160'(done), 160'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [159:0] held;
    for (int i = 0; i < 1024; i++) mem[i] = (32'h9E3779B9 * (i + 1)) ^ (i << 13);
    mem[1000] = 32'h00636261;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && digest == IV_EXP, "R1 reset", digest, IV_EXP);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: empty message
    launch(16'd0, 32'd0);
    wait_done("R3");
    check(digest == EMPTY_EXP, "R3 empty", digest, EMPTY_EXP);

    // R2: byte lane order, known answer
    launch(16'd4000, 32'd3);
    wait_done("R2");
    check(digest == ABC_EXP, "R2 abc", digest, ABC_EXP);

    // R4, R9: padding boundaries walked from the table
    for (int v = 0; v < NV; v++) begin
      launch(V_ADDR[v], V_LEN[v]);
      wait_done("R4");
      check(digest == ref_sha1(int'(V_ADDR[v]), int'(V_LEN[v])), "R4 table", digest,
            ref_sha1(int'(V_ADDR[v]), int'(V_LEN[v])));
    end

    // R7: done and digest hold without start
    held = digest;
    repeat (20) @(negedge clk);
    check(done && digest == held, "R7 hold", digest, held);

    // R7, R8: restart in the cycle done is high
    launch(16'd100, 32'd30);
    check(!done, "R7 start clears done", 160'(done), 160'd0);
    wait_done("R8");
    check(digest == ref_sha1(100, 30), "R8 back-to-back", digest, ref_sha1(100, 30));
    launch(16'd700, 32'd70);
    wait_done("R8");
    check(digest == ref_sha1(700, 70), "R8 second restart", digest, ref_sha1(700, 70));

    // R6: start during a running job is ignored
    launch(16'd3000, 32'd100);
    repeat (30) @(negedge clk);
    addr = 16'd0; len = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R6");
    check(digest == ref_sha1(3000, 100), "R6 busy start", digest, ref_sha1(3000, 100));

    // R1: reset in the middle of a job
    launch(16'd0, 32'd200);
    repeat (25) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!done && digest == IV_EXP, "R1 mid-job reset", digest, IV_EXP);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R8: clean job after reset
    launch(16'd64, 32'd20);
    wait_done("R8");
    check(digest == ref_sha1(64, 20), "R8 after reset", digest, ref_sha1(64, 20));

    // R5: memory port rules held throughout
    check(viol == 0, "R5 memory port", 160'(viol), 160'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule